// File: doc/BRIEF.md
# External Interrupt Enable, Pending and Priority Bank

This block keeps the per-line state of up to 64 external interrupt lines. Each line has four pieces of state: an enable bit, a pending bit, an active bit and a priority byte. Software reaches them over a simple 32-bit word-addressed register bus. Enable and pending state each have two addresses. Writing ones to the set address raises the selected bits and writing ones to the clear address lowers them, so a driver never has to read, modify and write back.

Raw interrupt lines raise pending bits. A combinational selector picks, from all lines that are pending, enabled and not active, the one with the numerically smallest priority byte. Ties go to the lower line number. The selector presents that line to the core as a request with its vector number, which is the line number plus 16. When the core acknowledges, the chosen line moves from pending to active. When the core reports completion of a vector, that line's active bit drops.

Top module: `irq_bank`

## Requirements
- R1: After a synchronous reset, every enable, pending, active and priority bit reads zero and `req_valid` is low.
- R2: Line n maps to word n>>5 at bit n&31. Writing ones to word address 0x00+word sets enable bits, and writing ones to 0x08+word clears them. Zero bits change nothing, and both addresses read back the current enable word.
- R3: Pending bits use set address 0x10+word and clear address 0x18+word with the same write-one behaviour as R2. Both addresses read the current pending word.
- R4: Word address 0x20+word reads the active bits. Writes to it are ignored.
- R5: The priority byte of line n sits at word address 0x40+(n>>2), bits [8*(n&3)+7 : 8*(n&3)]. It can be written and read back, and an address beyond the last line reads zero.
- R6: A rising edge on `irq_in[n]` sets pending bit n one clock later. A line held high does not set the bit again after it is cleared.
- R7: `req_valid` is high exactly when some line is pending, enabled and not active. `req_vector` is then that winner's number plus 16.
- R8: Among the candidate lines, the smallest priority byte wins. Equal bytes go to the lower line number.
- R9: `core_ack` while `req_valid` is high clears the winner's pending bit and sets its active bit at the next clock. `core_ack` while `req_valid` is low changes nothing.
- R10: `core_done` with `core_done_vector` = n+16 clears active bit n at the next clock. A vector below 16, or one beyond the last line, is ignored.
- R11: When a clear (register clear write or acknowledge) and a set hit the same pending bit in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_in | input | 64 | Raw interrupt lines, already synchronous to `clk` |
| core_ack | input | 1 | Core takes the presented request |
| core_done | input | 1 | Core finished the handler of `core_done_vector` |
| core_done_vector | input | 9 | Vector number being completed |
| req_valid | output | 1 | A candidate line exists |
| req_vector | output | 9 | Winner's vector number (line + 16) |

## Verification
The assertions assume three things about the inputs. The core acknowledges only what the block presents, so an acknowledge with no request must be harmless. A completion names a vector that is in use. The interrupt lines arrive already synchronised to the clock. The stimulus changes every input on the falling edge and issues acknowledges and completions as single-cycle pulses. It also sends completions for a vector below 16 on purpose, to confirm that such a vector is ignored.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W  = 7;
    localparam int VEC_W   = 9;
    localparam int VEC_OFS = 16;
    localparam int WORD_W  = 32;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENA_SET,
        SEL_ENA_CLR,
        SEL_PND_SET,
        SEL_PND_CLR,
        SEL_ACT,
        SEL_PRIO
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [5:0] idx;
    } dec_t;

    // bit 6 selects the priority window, bits 5:3 pick a bit-array group
    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.idx = {3'b000, a[2:0]};
        d.sel = SEL_NONE;
        if (a[6]) begin
            d.sel = SEL_PRIO;
            d.idx = a[5:0];
        end else begin
            case (a[5:3])
                3'd0:    d.sel = SEL_ENA_SET;
                3'd1:    d.sel = SEL_ENA_CLR;
                3'd2:    d.sel = SEL_PND_SET;
                3'd3:    d.sel = SEL_PND_CLR;
                3'd4:    d.sel = SEL_ACT;
                default: d.sel = SEL_NONE;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
    parameter int N           = 64,
    parameter bit LEVEL_SENSE = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] set_o
);
    generate
        if (LEVEL_SENSE) begin : g_level
            assign set_o = line_i;
        end else begin : g_edge
            logic [N-1:0] line_q;
            always_ff @(posedge clk) begin
                if (rst) line_q <= '0;
                else     line_q <= line_i;
            end
            assign set_o = line_i & ~line_q;
        end
    endgenerate
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_bank_pkg::*;
#(
    parameter int N      = 64,
    parameter int PRIO_W = 8,
    localparam int IDW   = $clog2(N),
    localparam int NWORD = N / WORD_W,
    localparam int LANES = WORD_W / PRIO_W,
    localparam int NPW   = N / LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic [N-1:0]      hw_set_i,
    input  logic              ack_en_i,
    input  logic [IDW-1:0]    ack_id_i,
    input  logic              done_en_i,
    input  logic [IDW-1:0]    done_id_i,
    output logic [N-1:0]      ena_o,
    output logic [N-1:0]      pnd_o,
    output logic [N-1:0]      act_o,
    output logic [PRIO_W-1:0] prio_o [N]
);
    dec_t d;
    assign d = decode(addr_i);

    logic [N-1:0] ena_q, pnd_q, act_q;
    logic [PRIO_W-1:0] prio_q [N];

    logic [N-1:0] ena_set, ena_clr, pnd_set, pnd_clr, ack_mask, done_mask;

    always_comb begin
        ena_set = '0; ena_clr = '0; pnd_set = '0; pnd_clr = '0;
        ack_mask = '0; done_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (wen_i && int'(d.idx) == i / WORD_W && wdata_i[i % WORD_W]) begin
                ena_set[i] = (d.sel == SEL_ENA_SET);
                ena_clr[i] = (d.sel == SEL_ENA_CLR);
                pnd_set[i] = (d.sel == SEL_PND_SET);
                pnd_clr[i] = (d.sel == SEL_PND_CLR);
            end
        end
        if (ack_en_i)  ack_mask[ack_id_i]   = 1'b1;
        if (done_en_i) done_mask[done_id_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= '0;
            pnd_q <= '0;
            act_q <= '0;
        end else begin
            ena_q <= (ena_q | ena_set) & ~ena_clr;
            // clears applied after sets: R11
            pnd_q <= (pnd_q | pnd_set | hw_set_i) & ~pnd_clr & ~ack_mask;
            act_q <= (act_q | ack_mask) & ~done_mask;
        end
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_prio
            always_ff @(posedge clk) begin
                if (rst) begin
                    prio_q[g] <= '0;
                end else if (wen_i && d.sel == SEL_PRIO && int'(d.idx) == g / LANES) begin
                    prio_q[g] <= wdata_i[(g % LANES)*PRIO_W +: PRIO_W];
                end
            end
            assign prio_o[g] = prio_q[g];
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (int'(d.idx) == w) begin
                case (d.sel)
                    SEL_ENA_SET, SEL_ENA_CLR: rdata_o = ena_q[w*WORD_W +: WORD_W];
                    SEL_PND_SET, SEL_PND_CLR: rdata_o = pnd_q[w*WORD_W +: WORD_W];
                    SEL_ACT:                  rdata_o = act_q[w*WORD_W +: WORD_W];
                    default: ;
                endcase
            end
        end
        if (d.sel == SEL_PRIO) begin
            for (int k = 0; k < NPW; k++) begin
                if (int'(d.idx) == k) begin
                    for (int j = 0; j < LANES; j++) begin
                        rdata_o[j*PRIO_W +: PRIO_W] = prio_q[k*LANES + j];
                    end
                end
            end
        end
    end

    assign ena_o = ena_q;
    assign pnd_o = pnd_q;
    assign act_o = act_q;

    // R4
    act_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wen_i && d.sel == SEL_ACT && !ack_en_i && !done_en_i) |=> act_q == $past(act_q));

    // R2
    ena_zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wen_i && (d.sel == SEL_ENA_SET || d.sel == SEL_ENA_CLR) && wdata_i == '0)
        |=> ena_q == $past(ena_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N      = 64,
    parameter int PRIO_W = 8,
    localparam int IDW   = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      cand_i,
    input  logic [PRIO_W-1:0] prio_i [N],
    output logic              valid_o,
    output logic [IDW-1:0]    id_o
);
    logic [PRIO_W-1:0] best_p;

    // strict less-than while scanning upward keeps the lower number on ties
    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        best_p  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (!valid_o || prio_i[i] < best_p)) begin
                valid_o = 1'b1;
                best_p  = prio_i[i];
                id_o    = IDW'(i);
            end
        end
    end

    logic beaten;
    always_comb begin
        beaten = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && (prio_i[i] < prio_i[id_o] ||
                              (prio_i[i] == prio_i[id_o] && IDW'(i) < id_o)))
                beaten = 1'b1;
        end
    end

    // R8
    winner_min_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (cand_i[id_o] && !beaten));

    // R7
    valid_iff_cand_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o == (|cand_i));
endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int N           = 64,
    parameter int PRIO_W      = 8,
    parameter bit LEVEL_SENSE = 1'b0,
    localparam int IDW        = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N-1:0]      irq_in,
    input  logic              core_ack,
    input  logic              core_done,
    input  logic [8:0]        core_done_vector,
    output logic              req_valid,
    output logic [8:0]        req_vector
);
    logic [N-1:0]      hw_set, ena, pnd, act;
    logic [PRIO_W-1:0] prio [N];
    logic              win_valid;
    logic [IDW-1:0]    win_id;
    logic              ack_en, done_en;
    logic [IDW-1:0]    done_id;

    irq_sense #(.N(N), .LEVEL_SENSE(LEVEL_SENSE)) u_sense (
        .clk(clk), .rst(rst), .line_i(irq_in), .set_o(hw_set)
    );

    assign ack_en  = core_ack && win_valid;
    assign done_en = core_done && int'(core_done_vector) >= VEC_OFS
                                && int'(core_done_vector) < VEC_OFS + N;
    assign done_id = IDW'(core_done_vector - VEC_W'(VEC_OFS));

    irq_reg_file #(.N(N), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst(rst),
        .wen_i(bus_wen), .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .hw_set_i(hw_set),
        .ack_en_i(ack_en), .ack_id_i(win_id),
        .done_en_i(done_en), .done_id_i(done_id),
        .ena_o(ena), .pnd_o(pnd), .act_o(act), .prio_o(prio)
    );

    irq_arbiter #(.N(N), .PRIO_W(PRIO_W)) u_arb (
        .clk(clk), .rst(rst),
        .cand_i(pnd & ena & ~act), .prio_i(prio),
        .valid_o(win_valid), .id_o(win_id)
    );

    assign req_valid  = win_valid;
    assign req_vector = win_valid ? VEC_W'(win_id) + VEC_W'(VEC_OFS) : '0;

    // R9
    ack_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ack && req_valid) |=> (act[$past(win_id)] && !pnd[$past(win_id)]));

    // R9
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (core_ack && !req_valid && !core_done) |=> act == $past(act));

    // R10
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        done_en |=> !act[$past(done_id)]);

    // R7
    req_range_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (int'(req_vector) >= VEC_OFS && int'(req_vector) < VEC_OFS + N));
endmodule

// File: tb/tb_irq_bank.sv
module tb_irq_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wen;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] irq_in;
    logic        core_ack, core_done;
    logic [8:0]  core_done_vector;
    logic        req_valid;
    logic [8:0]  req_vector;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_bank dut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .core_ack(core_ack), .core_done(core_done),
        .core_done_vector(core_done_vector),
        .req_valid(req_valid), .req_vector(req_vector)
    );

    typedef struct packed {
        logic        wr;
        logic [6:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } op_t;

    localparam int NOPS = 22;
    localparam op_t TBL [NOPS] = '{
        '{1'b1, 7'h00, 32'h0000_00F0, 4'd2},
        '{1'b0, 7'h00, 32'h0000_00F0, 4'd2},
        '{1'b0, 7'h08, 32'h0000_00F0, 4'd2},
        '{1'b1, 7'h00, 32'h0000_0000, 4'd2},
        '{1'b0, 7'h00, 32'h0000_00F0, 4'd2},
        '{1'b1, 7'h08, 32'h0000_0030, 4'd2},
        '{1'b0, 7'h00, 32'h0000_00C0, 4'd2},
        '{1'b1, 7'h01, 32'h8000_0001, 4'd2},
        '{1'b0, 7'h09, 32'h8000_0001, 4'd2},
        '{1'b1, 7'h10, 32'h0000_0100, 4'd3},
        '{1'b0, 7'h18, 32'h0000_0100, 4'd3},
        '{1'b1, 7'h18, 32'h0000_0000, 4'd3},
        '{1'b0, 7'h10, 32'h0000_0100, 4'd3},
        '{1'b1, 7'h18, 32'h0000_0100, 4'd3},
        '{1'b0, 7'h10, 32'h0000_0000, 4'd3},
        '{1'b1, 7'h20, 32'hFFFF_FFFF, 4'd4},
        '{1'b0, 7'h20, 32'h0000_0000, 4'd4},
        '{1'b1, 7'h41, 32'hA1B2_C3D4, 4'd5},
        '{1'b0, 7'h41, 32'hA1B2_C3D4, 4'd5},
        '{1'b1, 7'h4F, 32'h1122_3344, 4'd5},
        '{1'b0, 7'h4F, 32'h1122_3344, 4'd5},
        '{1'b0, 7'h7F, 32'h0000_0000, 4'd5}
    };

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_ack;
        @(negedge clk); core_ack = 1'b1;
        @(negedge clk); core_ack = 1'b0;
    endtask

    task automatic pulse_done(input logic [8:0] v);
        @(negedge clk); core_done = 1'b1; core_done_vector = v;
        @(negedge clk); core_done = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0;
        irq_in = '0; core_ack = 1'b0; core_done = 1'b0; core_done_vector = '0;
        do_reset();

        // R2 R3 R4 R5 table walk
        for (int k = 0; k < NOPS; k++) begin
            if (TBL[k].wr) bus_write(TBL[k].addr, TBL[k].data);
            else read_chk($sformatf("R%0d table op %0d", TBL[k].req, k), TBL[k].addr, TBL[k].data);
        end

        // R1 reset clears everything the table left behind
        bus_write(7'h10, 32'h0000_0040);
        do_reset();
        read_chk("R1 enable", 7'h00, 32'h0);
        read_chk("R1 pending", 7'h10, 32'h0);
        read_chk("R1 active", 7'h20, 32'h0);
        read_chk("R1 prio", 7'h41, 32'h0);
        check("R1 req_valid", {31'b0, req_valid}, 32'd0);

        // R8 priority: irq5 prio 0x40, irq40 prio 0x20 -> irq40 wins (vector 56)
        bus_write(7'h00, 32'h0000_0020);
        bus_write(7'h01, 32'h0000_0100);
        bus_write(7'h41, 32'h0000_4000);
        bus_write(7'h4A, 32'h0000_0020);
        bus_write(7'h10, 32'h0000_0020);
        bus_write(7'h11, 32'h0000_0100);
        #1;
        check("R7 req_valid", {31'b0, req_valid}, 32'd1);
        check("R8 lower byte wins", {23'b0, req_vector}, 32'd56);

        // R9 acknowledge
        pulse_ack();
        read_chk("R9 active after ack", 7'h21, 32'h0000_0100);
        read_chk("R9 pending after ack", 7'h11, 32'h0);
        check("R7 next winner", {23'b0, req_vector}, 32'd21);
        pulse_ack();
        read_chk("R9 second ack", 7'h20, 32'h0000_0020);
        check("R7 no candidate", {31'b0, req_valid}, 32'd0);

        // R10 completion
        pulse_done(9'd56);
        read_chk("R10 done clears", 7'h21, 32'h0);
        pulse_done(9'd5);
        read_chk("R10 vector below 16 ignored", 7'h20, 32'h0000_0020);
        pulse_done(9'd21);
        read_chk("R10 done second", 7'h20, 32'h0);

        // R9 ack with no request
        pulse_ack();
        read_chk("R9 idle ack", 7'h20, 32'h0);

        // R8 tie: irq3 and irq7 both prio 0 -> vector 19
        bus_write(7'h00, 32'h0000_0088);
        bus_write(7'h10, 32'h0000_0088);
        #1;
        check("R8 tie lower number", {23'b0, req_vector}, 32'd19);
        bus_write(7'h08, 32'h0000_0008);
        #1;
        check("R2 disable drops winner", {23'b0, req_vector}, 32'd23);

        // R6 edge sensing
        bus_write(7'h18, 32'h0000_0080);
        read_chk("R3 clear pending", 7'h10, 32'h0000_0008);
        @(negedge clk); irq_in[7] = 1'b1;
        @(negedge clk);
        read_chk("R6 edge sets pending", 7'h10, 32'h0000_0088);
        bus_write(7'h18, 32'h0000_0080);
        @(negedge clk);
        read_chk("R6 held line no re-pend", 7'h10, 32'h0000_0008);
        irq_in[7] = 1'b0;
        @(negedge clk); irq_in[7] = 1'b1;
        @(negedge clk);
        read_chk("R6 new edge", 7'h10, 32'h0000_0088);

        // R11 clear and edge in the same cycle: clear wins
        irq_in[9] = 1'b0;
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = 7'h18; bus_wdata = 32'h0000_0200; irq_in[9] = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
        read_chk("R11 clear beats edge", 7'h10, 32'h0000_0088);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule